// File: doc/BRIEF.md
# PCI Target Register Access Decoder

This block is the target-side front end that lets a PCI master reach a small bank of internal 32-bit registers. It does not handle bus electrical signalling or parity. Instead it receives one already-decoded data phase per cycle: the command nibble, the address, active-low byte enables, write data, an IDSEL indication, and markers for the first and last data phase of a transaction. The last-phase marker reflects FRAME# being released. For each phase the block decides whether to claim it, applies any register write, returns read data, and flags a target disconnect when the transaction has to be cut short.

Three kinds of access are claimed. Configuration Type 0 cycles reach a command register and two base address registers. Memory cycles that fall inside the window of the memory base address register reach the register bank. I/O cycles that fall inside the window of the I/O base address register reach the same bank. Memory bursts walk through consecutive registers. Any burst to I/O or configuration space ends after its first data phase with a disconnect.

All responses are registered. A phase presented in cycle N is answered by the outputs in cycle N+1.

Top module: `pci_reg_target`

## Requirements
- R1: After reset the command register and both base address registers are zero. With decode disabled, no memory or I/O cycle is claimed, and all response outputs stay low until a phase is presented.
- R2: A configuration cycle is claimed only if three conditions hold: the command is 4'hA (read) or 4'hB (write), IDSEL is high, and address bits [1:0] are 2'b00. The dword index is address bits [7:2]. Index 1 reads back {30'b0, mem_en, io_en}, index 4 is the memory base, index 5 is the I/O base, and every other index reads zero.
- R3: In the memory base, only bits [31:MEM_WIN_BITS] are writable and the lower bits read as zero. In the I/O base, only bits [31:IO_WIN_BITS] are writable, bit 0 reads as one, and the remaining low bits read as zero. A write to index 1 with lane 0 enabled loads io_en from data bit 0 and mem_en from data bit 1.
- R4: A memory cycle (4'h6 read, 4'h7 write) is claimed only if mem_en is set and address bits [31:MEM_WIN_BITS] equal the memory base. The register index is address bits [MEM_WIN_BITS-1:2].
- R5: An I/O cycle (4'h2 read, 4'h3 write) is claimed only if io_en is set and address bits [31:IO_WIN_BITS] equal the I/O base. It indexes the same register bank as memory space.
- R6: A write changes only the byte lanes whose active-low enable is 0. Lane k covers data bits [8k+7:8k]. A read always returns all 32 bits, and a write with no lane enabled changes nothing.
- R7: In a memory burst, each later phase addresses the next register, and every phase is claimed without a disconnect until the last phase.
- R8: When an I/O or configuration transaction is not on its last phase, its first phase is claimed with a disconnect. Any further phases of that transaction are not claimed and write nothing.
- R9: A memory burst phase that addresses the final dword of the window and is not the last phase is claimed with a disconnect. The following phases are not claimed.
- R10: A claimed window offset at or above NUM_REGS reads zero, and writes to it are dropped.
- R11: reg_wr_o or reg_rd_o pulses together with the response of each claimed register-bank write or read, with reg_idx_o giving the index. Both stay low for configuration accesses and unclaimed phases.
- R12: rsp_valid_o is high exactly in the cycle after each presented phase. An unclaimed phase responds with claim, stop and read data all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A data phase is presented this cycle |
| req_first_i | input | 1 | Phase is the first of its transaction (address valid) |
| req_last_i | input | 1 | Phase is the last of its transaction |
| req_cmd_i | input | 4 | PCI bus command |
| req_idsel_i | input | 1 | IDSEL sampled for this transaction |
| req_addr_i | input | 32 | Transaction address |
| req_be_ni | input | 4 | Byte enables, active low |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's phase |
| rsp_claim_o | output | 1 | Phase was claimed |
| rsp_stop_o | output | 1 | Target disconnect with this phase's data |
| rsp_rdata_o | output | 32 | Read data |
| reg_wr_o | output | 1 | Register-bank write strobe |
| reg_rd_o | output | 1 | Register-bank read strobe |
| reg_idx_o | output | IDX_W | Register index accessed |

## Verification
The bench concentrates on three things: the disconnect on I/O and configuration bursts, the disconnect at the window end of a memory burst, and byte-lane merging. If a design disconnected too late, the second I/O phase would overwrite the next register. If it disconnected too early, a memory burst would lose phases. If it merged lanes wrongly, bytes written as zero would appear in the wrong positions. The bench also targets base-register masking and the enable bits. A wrong mask would show up as read-back low bits or as claims of addresses just outside the window. Ignoring an enable bit would claim cycles after reset or after decode has been turned off. Out-of-range offsets and configuration cycles without IDSEL are probed to catch stray writes or stray claims.

// File: rtl/pci_reg_target_pkg.sv
package pci_reg_target_pkg;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_CFG  = 2'd1,
    SP_MEM  = 2'd2,
    SP_IO   = 2'd3
  } space_e;

  localparam logic [3:0] CMD_IO_RD  = 4'h2;
  localparam logic [3:0] CMD_IO_WR  = 4'h3;
  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  localparam int CFG_IDX_W = 6;
  localparam logic [CFG_IDX_W-1:0] CFG_CMD_IDX  = 6'd1;
  localparam logic [CFG_IDX_W-1:0] CFG_BAR0_IDX = 6'd4;
  localparam logic [CFG_IDX_W-1:0] CFG_BAR1_IDX = 6'd5;

  // expand active-low byte enables to a bit mask of written bits
  function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{~be_n[l]}};
    return m;
  endfunction

endpackage

// File: rtl/prt_space_decode.sv
module prt_space_decode
  import pci_reg_target_pkg::*;
#(
  parameter int MEM_WIN_BITS = 8,
  parameter int IO_WIN_BITS  = 8,
  parameter int IDX_W        = 6,
  localparam int MEM_HI_W    = 32 - MEM_WIN_BITS,
  localparam int IO_HI_W     = 32 - IO_WIN_BITS
) (
  input  logic [3:0]           cmd_i,
  input  logic                 idsel_i,
  input  logic [31:0]          addr_i,
  input  logic                 mem_en_i,
  input  logic                 io_en_i,
  input  logic [MEM_HI_W-1:0]  bar0_hi_i,
  input  logic [IO_HI_W-1:0]   bar1_hi_i,
  output space_e               space_o,
  output logic                 write_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [CFG_IDX_W-1:0] cfg_idx_o
);

  logic is_cfg, is_mem, is_io;

  always_comb begin
    is_cfg = (cmd_i == CMD_CFG_RD || cmd_i == CMD_CFG_WR) && idsel_i && (addr_i[1:0] == 2'b00);
    is_mem = (cmd_i == CMD_MEM_RD || cmd_i == CMD_MEM_WR) && mem_en_i &&
             (addr_i[31:MEM_WIN_BITS] == bar0_hi_i);
    is_io  = (cmd_i == CMD_IO_RD || cmd_i == CMD_IO_WR) && io_en_i &&
             (addr_i[31:IO_WIN_BITS] == bar1_hi_i);

    space_o = SP_NONE;
    idx_o   = '0;
    if (is_cfg) begin
      space_o = SP_CFG;
    end else if (is_mem) begin
      space_o = SP_MEM;
      idx_o   = IDX_W'(addr_i[MEM_WIN_BITS-1:2]);
    end else if (is_io) begin
      space_o = SP_IO;
      idx_o   = IDX_W'(addr_i[IO_WIN_BITS-1:2]);
    end
    write_o   = cmd_i[0];
    cfg_idx_o = addr_i[7:2];
  end

endmodule

// File: rtl/prt_cfg_regs.sv
module prt_cfg_regs
  import pci_reg_target_pkg::*;
#(
  parameter int MEM_WIN_BITS = 8,
  parameter int IO_WIN_BITS  = 8,
  localparam int MEM_HI_W    = 32 - MEM_WIN_BITS,
  localparam int IO_HI_W     = 32 - IO_WIN_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [CFG_IDX_W-1:0] idx_i,
  input  logic [3:0]           be_ni,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [MEM_HI_W-1:0]  bar0_hi_o,
  output logic [IO_HI_W-1:0]   bar1_hi_o,
  output logic                 mem_en_o,
  output logic                 io_en_o
);

  logic [MEM_HI_W-1:0] bar0_q;
  logic [IO_HI_W-1:0]  bar1_q;
  logic                mem_en_q, io_en_q;
  logic [31:0]         wmask;
  logic                unused_wdata;

  assign wmask        = lane_mask(be_ni);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar0_q   <= '0;
      bar1_q   <= '0;
      mem_en_q <= 1'b0;
      io_en_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (idx_i)
        CFG_CMD_IDX: if (!be_ni[0]) begin
          io_en_q  <= wdata_i[0];
          mem_en_q <= wdata_i[1];
        end
        CFG_BAR0_IDX: bar0_q <= (bar0_q & ~wmask[31:MEM_WIN_BITS]) |
                                (wdata_i[31:MEM_WIN_BITS] & wmask[31:MEM_WIN_BITS]);
        CFG_BAR1_IDX: bar1_q <= (bar1_q & ~wmask[31:IO_WIN_BITS]) |
                                (wdata_i[31:IO_WIN_BITS] & wmask[31:IO_WIN_BITS]);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx_i)
      CFG_CMD_IDX:  rdata_o = {30'b0, mem_en_q, io_en_q};
      CFG_BAR0_IDX: rdata_o = {bar0_q, {MEM_WIN_BITS{1'b0}}};
      CFG_BAR1_IDX: rdata_o = {bar1_q, {(IO_WIN_BITS-1){1'b0}}, 1'b1};
      default:      rdata_o = '0;
    endcase
  end

  assign bar0_hi_o = bar0_q;
  assign bar1_hi_o = bar1_q;
  assign mem_en_o  = mem_en_q;
  assign io_en_o   = io_en_q;

endmodule

// File: rtl/prt_reg_file.sv
module prt_reg_file
  import pci_reg_target_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_ni,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);

  logic [31:0] wmask;
  logic [31:0] rd_vec [NUM_REGS];

  assign wmask = lane_mask(be_ni);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [31:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && idx_i == IDX_W'(r)) q <= (q & ~wmask) | (wdata_i & wmask);
    end
    assign rd_vec[r] = q;
  end

  // offsets past NUM_REGS fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == IDX_W'(i)) rdata_o = rd_vec[i];
  end

endmodule

// File: rtl/pci_reg_target.sv
module pci_reg_target
  import pci_reg_target_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int MEM_WIN_BITS = 8,
  parameter int IO_WIN_BITS  = 8,
  localparam int IDX_W       = ((MEM_WIN_BITS > IO_WIN_BITS) ? MEM_WIN_BITS : IO_WIN_BITS) - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_first_i,
  input  logic             req_last_i,
  input  logic [3:0]       req_cmd_i,
  input  logic             req_idsel_i,
  input  logic [31:0]      req_addr_i,
  input  logic [3:0]       req_be_ni,
  input  logic [31:0]      req_wdata_i,
  output logic             rsp_valid_o,
  output logic             rsp_claim_o,
  output logic             rsp_stop_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             reg_wr_o,
  output logic             reg_rd_o,
  output logic [IDX_W-1:0] reg_idx_o
);

  localparam int MEM_HI_W = 32 - MEM_WIN_BITS;
  localparam int IO_HI_W  = 32 - IO_WIN_BITS;
  localparam logic [IDX_W-1:0] MEM_LAST = IDX_W'((1 << (MEM_WIN_BITS - 2)) - 1);

  space_e               dec_space, cur_space, txn_space_q;
  logic                 dec_write, cur_write, txn_write_q, txn_live_q;
  logic [IDX_W-1:0]     dec_idx, cur_idx, txn_idx_q;
  logic [CFG_IDX_W-1:0] cfg_idx;
  logic [MEM_HI_W-1:0]  bar0_hi;
  logic [IO_HI_W-1:0]   bar1_hi;
  logic                 mem_en, io_en;
  logic                 claim, stop, rf_wr, rf_rd, cfg_wr;
  logic [31:0]          cfg_rdata, rf_rdata, rd_sel;

  prt_space_decode #(
    .MEM_WIN_BITS(MEM_WIN_BITS),
    .IO_WIN_BITS (IO_WIN_BITS),
    .IDX_W       (IDX_W)
  ) u_decode (
    .cmd_i    (req_cmd_i),
    .idsel_i  (req_idsel_i),
    .addr_i   (req_addr_i),
    .mem_en_i (mem_en),
    .io_en_i  (io_en),
    .bar0_hi_i(bar0_hi),
    .bar1_hi_i(bar1_hi),
    .space_o  (dec_space),
    .write_o  (dec_write),
    .idx_o    (dec_idx),
    .cfg_idx_o(cfg_idx)
  );

  // phase context: address phase decode, or the live transaction
  always_comb begin
    if (req_first_i) begin
      cur_space = dec_space;
      cur_write = dec_write;
      cur_idx   = dec_idx;
    end else if (txn_live_q) begin
      cur_space = txn_space_q;
      cur_write = txn_write_q;
      cur_idx   = txn_idx_q;
    end else begin
      cur_space = SP_NONE;
      cur_write = 1'b0;
      cur_idx   = '0;
    end
    claim  = req_valid_i && (cur_space != SP_NONE);
    // only memory space may burst, and never past the window end
    stop   = claim && !req_last_i && ((cur_space != SP_MEM) || (cur_idx == MEM_LAST));
    rf_wr  = claim && cur_write  && (cur_space == SP_MEM || cur_space == SP_IO);
    rf_rd  = claim && !cur_write && (cur_space == SP_MEM || cur_space == SP_IO);
    cfg_wr = claim && cur_write  && (cur_space == SP_CFG);
    rd_sel = (cur_space == SP_CFG) ? cfg_rdata : rf_rdata;
  end

  prt_cfg_regs #(
    .MEM_WIN_BITS(MEM_WIN_BITS),
    .IO_WIN_BITS (IO_WIN_BITS)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .idx_i    (cfg_idx),
    .be_ni    (req_be_ni),
    .wdata_i  (req_wdata_i),
    .rdata_o  (cfg_rdata),
    .bar0_hi_o(bar0_hi),
    .bar1_hi_o(bar1_hi),
    .mem_en_o (mem_en),
    .io_en_o  (io_en)
  );

  prt_reg_file #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (rf_wr),
    .idx_i  (cur_idx),
    .be_ni  (req_be_ni),
    .wdata_i(req_wdata_i),
    .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txn_live_q  <= 1'b0;
      txn_space_q <= SP_NONE;
      txn_write_q <= 1'b0;
      txn_idx_q   <= '0;
    end else if (req_valid_i) begin
      if (req_first_i) begin
        txn_live_q  <= claim && !req_last_i && !stop;
        txn_space_q <= cur_space;
        txn_write_q <= cur_write;
        txn_idx_q   <= cur_idx + 1'b1;
      end else if (txn_live_q) begin
        txn_live_q <= !req_last_i && !stop;
        txn_idx_q  <= cur_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_claim_o <= 1'b0;
      rsp_stop_o  <= 1'b0;
      rsp_rdata_o <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_idx_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_claim_o <= claim;
      rsp_stop_o  <= stop;
      rsp_rdata_o <= (claim && !cur_write) ? rd_sel : '0;
      reg_wr_o    <= rf_wr;
      reg_rd_o    <= rf_rd;
      reg_idx_o   <= (rf_wr || rf_rd) ? cur_idx : '0;
    end
  end

endmodule

// File: rtl/pci_reg_target_chk.sv
module pci_reg_target_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_first_i,
  input logic             req_last_i,
  input logic [3:0]       req_cmd_i,
  input logic             req_idsel_i,
  input logic [31:0]      req_addr_i,
  input logic [3:0]       req_be_ni,
  input logic [31:0]      req_wdata_i,
  input logic             rsp_valid_o,
  input logic             rsp_claim_o,
  input logic             rsp_stop_o,
  input logic [31:0]      rsp_rdata_o,
  input logic             reg_wr_o,
  input logic             reg_rd_o,
  input logic [IDX_W-1:0] reg_idx_o
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R12

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R12

  AST_UNCLAIMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_claim_o |-> (!rsp_stop_o && rsp_rdata_o == 32'h0 && !reg_wr_o && !reg_rd_o)); // R12

  AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_claim_o |-> rsp_valid_o); // R12

  AST_LAST_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_last_i) |=> !rsp_stop_o); // R7

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o})); // R11

  AST_WRITE_NO_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> rsp_rdata_o == 32'h0); // R11

  AST_IDX_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o || reg_rd_o) |-> reg_idx_o == '0); // R11

endmodule

bind pci_reg_target pci_reg_target_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/pci_reg_target_bench.sv
`timescale 1ns/1ps
module pci_reg_target_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_first_i = 1'b0, req_last_i = 1'b0, req_idsel_i = 1'b0;
  logic [3:0]  req_cmd_i = '0, req_be_ni = 4'hF;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        rsp_valid_o, rsp_claim_o, rsp_stop_o, reg_wr_o, reg_rd_o;
  logic [31:0] rsp_rdata_o;
  logic [5:0]  reg_idx_o;

  int errors = 0, checks = 0;
  bit done = 0;

  pci_reg_target u_pci_reg_target (.*);

  always #4 clk_i = ~clk_i;

  // bench model state
  bit          m_io_en, m_mem_en;
  logic [31:0] m_bar0, m_bar1;
  logic [31:0] m_regs [16];
  int          t_space, t_idx;
  bit          t_write, t_live;
  logic [31:0] last_rd;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] ben);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (!ben[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic phase(input logic [3:0] cmd, input bit idsel, input logic [31:0] addr,
                       input logic [3:0] ben, input logic [31:0] wd,
                       input bit first, input bit last, input string req);
    int sp, idx; bit wr, claim, stop, rfw, rfr; logic [31:0] erd;
    sp = 0; idx = 0; wr = 0;
    if (first) begin
      wr  = cmd[0];
      idx = int'(addr[7:2]);
      if ((cmd == 4'hA || cmd == 4'hB) && idsel && addr[1:0] == 2'b00) sp = 1;
      else if ((cmd == 4'h6 || cmd == 4'h7) && m_mem_en && addr[31:8] == m_bar0[31:8]) sp = 2;
      else if ((cmd == 4'h2 || cmd == 4'h3) && m_io_en && addr[31:8] == m_bar1[31:8]) sp = 3;
    end else if (t_live) begin
      sp = t_space; wr = t_write; idx = t_idx;
    end
    claim = (sp != 0);
    stop  = claim && !last && (sp != 2 || idx == 63);
    rfw   = claim && wr && sp >= 2;
    rfr   = claim && !wr && sp >= 2;
    erd   = 32'h0;
    if (claim && !wr) begin
      if (sp == 1) begin
        case (idx)
          1: erd = {30'b0, m_mem_en, m_io_en};
          4: erd = m_bar0;
          5: erd = m_bar1 | 32'h1;
          default: erd = 32'h0;
        endcase
      end else erd = (idx < 16) ? m_regs[idx] : 32'h0;
    end

    @(negedge clk_i);
    req_valid_i = 1; req_first_i = first; req_last_i = last; req_cmd_i = cmd;
    req_idsel_i = idsel; req_addr_i = addr; req_be_ni = ben; req_wdata_i = wd;
    @(posedge clk_i); #1;
    req_valid_i = 0;
    last_rd = rsp_rdata_o;
    chk(rsp_valid_o === 1'b1, req, "valid", rsp_valid_o, 1);
    chk(rsp_claim_o === claim, req, "claim", rsp_claim_o, claim);
    chk(rsp_stop_o === stop, req, "stop", rsp_stop_o, stop);
    chk(rsp_rdata_o === erd, req, "rdata", rsp_rdata_o, erd);
    chk(reg_wr_o === rfw && reg_rd_o === rfr, req, "strobes", {reg_wr_o, reg_rd_o}, {rfw, rfr});
    chk(reg_idx_o === ((rfw || rfr) ? 6'(idx) : 6'd0), req, "idx", reg_idx_o,
        (rfw || rfr) ? idx : 0);

    if (claim && wr) begin
      if (sp == 1) begin
        if (idx == 1 && !ben[0]) begin m_io_en = wd[0]; m_mem_en = wd[1]; end
        if (idx == 4) m_bar0 = merge(m_bar0, wd, ben) & 32'hFFFF_FF00;
        if (idx == 5) m_bar1 = merge(m_bar1, wd, ben) & 32'hFFFF_FF00;
      end else if (idx < 16) m_regs[idx] = merge(m_regs[idx], wd, ben);
    end
    if (first) begin
      t_live = claim && !last && !stop; t_space = sp; t_write = wr; t_idx = idx + 1;
    end else if (t_live) begin
      t_live = !last && !stop; t_idx = idx + 1;
    end
  endtask

  task automatic burst(input logic [3:0] cmd, input logic [31:0] addr, input int len,
                       input logic [31:0] seed_data, input string req);
    for (int p = 0; p < len; p++)
      phase(cmd, 0, addr, 4'h0, seed_data + 32'(p) * 32'h0101_0101, p == 0, p == len - 1, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_io_en = 0; m_mem_en = 0; m_bar0 = 0; m_bar1 = 0; t_live = 0; t_space = 0;
    t_idx = 0; t_write = 0;
    for (int i = 0; i < 16; i++) m_regs[i] = 32'h0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(posedge clk_i); #1;
    chk(!rsp_valid_o && !rsp_claim_o && !rsp_stop_o && rsp_rdata_o == 0 && !reg_wr_o && !reg_rd_o,
        "R1", "reset outputs", {rsp_valid_o, rsp_claim_o, rsp_stop_o}, 0);
    phase(4'h6, 0, 32'h0000_0010, 4'h0, 0, 1, 1, "R1");
    phase(4'h2, 0, 32'h0000_0010, 4'h0, 0, 1, 1, "R1");

    // configuration: base registers and enables
    phase(4'hB, 1, 32'h0000_0010, 4'h0, 32'h8000_1234, 1, 1, "R3");
    phase(4'hA, 1, 32'h0000_0010, 4'h0, 0, 1, 1, "R3");
    chk(last_rd == 32'h8000_1200, "R3", "bar0 readback", last_rd, 32'h8000_1200);
    phase(4'hB, 1, 32'h0000_0014, 4'h0, 32'h0000_C0FF, 1, 1, "R3");
    phase(4'hA, 1, 32'h0000_0014, 4'h0, 0, 1, 1, "R3");
    chk(last_rd == 32'h0000_C001, "R3", "bar1 readback", last_rd, 32'h0000_C001);
    phase(4'hB, 0, 32'h0000_0004, 4'h0, 32'h3, 1, 1, "R2");
    phase(4'hB, 1, 32'h0000_0005, 4'h0, 32'h3, 1, 1, "R2");
    phase(4'hB, 1, 32'h0000_0004, 4'h0, 32'h3, 1, 1, "R2");
    phase(4'hA, 1, 32'h0000_0004, 4'h0, 0, 1, 1, "R2");
    chk(last_rd == 32'h3, "R2", "command readback", last_rd, 3);
    phase(4'hA, 1, 32'h0000_0020, 4'h0, 0, 1, 1, "R2");

    // memory burst of four longwords, write then read back
    burst(4'h7, 32'h8000_1210, 4, 32'hA0B0_C0D0, "R7");
    burst(4'h6, 32'h8000_1210, 4, 0, "R7");
    phase(4'h6, 0, 32'h8000_1310, 4'h0, 0, 1, 1, "R4");
    phase(4'h6, 0, 32'h8000_121C, 4'h0, 0, 1, 1, "R4");
    chk(last_rd == 32'hA3B3_C3D3, "R7", "burst data", last_rd, 32'hA3B3_C3D3);

    // I/O burst: disconnect after first phase, second phase dropped
    burst(4'h3, 32'h0000_C024, 2, 32'h1111_2222, "R8");
    phase(4'h2, 0, 32'h0000_C024, 4'h0, 0, 1, 1, "R5");
    phase(4'h6, 0, 32'h8000_1228, 4'h0, 0, 1, 1, "R8");
    chk(last_rd == 32'h0, "R8", "second io phase dropped", last_rd, 0);
    phase(4'h2, 0, 32'h0000_C124, 4'h0, 0, 1, 1, "R5");
    burst(4'hA, 32'h0000_0010, 2, 0, "R8");

    // byte lanes
    phase(4'h7, 0, 32'h8000_1208, 4'h0, 32'hFFFF_FFFF, 1, 1, "R6");
    phase(4'h7, 0, 32'h8000_1208, 4'b1010, 32'h0, 1, 1, "R6");
    phase(4'h7, 0, 32'h8000_1208, 4'hF, 32'h0, 1, 1, "R6");
    phase(4'h3, 0, 32'h0000_C008, 4'b0111, 32'h5A00_0000, 1, 1, "R6");
    phase(4'h6, 0, 32'h8000_1208, 4'h0, 0, 1, 1, "R6");
    chk(last_rd == 32'h5A00_FF00, "R6", "lane merge", last_rd, 32'h5A00_FF00);

    // window end and out-of-range offsets
    burst(4'h7, 32'h8000_12F8, 3, 32'h7777_0000, "R9");
    phase(4'h6, 0, 32'h8000_12FC, 4'h0, 0, 1, 1, "R10");
    chk(last_rd == 32'h0, "R10", "high offset reads zero", last_rd, 0);
    phase(4'h6, 0, 32'h8000_1240, 4'h0, 0, 1, 1, "R10");

    // constrained random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 9);
      logic [31:0] off = {24'h0, 6'($urandom_range(0, 63)), 2'b00};
      logic [3:0] ben = 4'($urandom_range(0, 15));
      logic [31:0] wd = $urandom;
      int len = $urandom_range(1, 4);
      if (kind < 4) begin
        for (int p = 0; p < len; p++)
          phase(kind[0] ? 4'h7 : 4'h6, 0, (kind == 3 ? 32'h8000_1300 : 32'h8000_1200) | off,
                ben, wd ^ 32'(p), p == 0, p == len - 1, "R4");
      end else if (kind < 7) begin
        for (int p = 0; p < len; p++)
          phase(kind[0] ? 4'h3 : 4'h2, 0, (kind == 6 ? 32'h0001_C000 : 32'h0000_C000) | off,
                ben, wd, p == 0, p == len - 1, "R5");
      end else begin
        phase(4'hA, 1'($urandom_range(0, 1)), off | 32'(2'($urandom_range(0, 3)) == 0 ? 0 : 1),
              ben, 0, 1, 1, "R2");
      end
    end

    // memory decode disabled, I/O still on
    phase(4'hB, 1, 32'h0000_0004, 4'h0, 32'h1, 1, 1, "R4");
    phase(4'h6, 0, 32'h8000_1200, 4'h0, 0, 1, 1, "R4");
    phase(4'h2, 0, 32'h0000_C000, 4'h0, 0, 1, 1, "R11");
    @(posedge clk_i); #1;
    chk(!rsp_valid_o, "R12", "idle after traffic", rsp_valid_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule